// File: doc/BRIEF.md
# Bit-Serial Multiplierless Dot Product

This block forms the inner product of K constant coefficients with K signed input samples, and it uses no multiplier. A start strobe captures all K samples, each an N-bit two's complement fraction, into parallel-load shift registers. On each of the next N cycles the block takes one bit from every sample, least significant bit first. Those K bits form an address into a table of precomputed coefficient partial sums. A shift-right accumulator then adds the table word, or subtracts it when the bit slice holds the sign bits.

The coefficients are fixed when the block is built and are quantized to M-bit signed fixed point. The result is the exact integer dot product of the coefficient integers and the sample integers, so the binary point of the result is the sum of the two fractional scalings. The result is registered and comes with a one-cycle done pulse. It stays unchanged until the next computation completes.

Top module: `da_dot_product`

## Requirements
- R1: While reset is high and on the cycle after it, `done` is 0. After reset `result` reads 0 and no computation is in progress.
- R2: `result` equals the exact signed integer sum over k of COEFS[k]·x_k. Sample k sits in `samples[k*N +: N]` as an N-bit two's complement integer, and coefficient k sits in `COEFS[k*M +: M]` as an M-bit two's complement integer.
- R3: The table word at address e is the sum of the coefficients k for which bit k of e is 1. Address bit k comes from sample k, so address 0 gives zero. A sample of value 1 in lane k alone gives COEFS[k].
- R4: The bit slice taken from the sign bits (bit N-1) is subtracted and every other slice is added. All samples at the most negative value −2^(N−1) give −2^(N−1)·ΣCOEFS.
- R5: The bits are consumed least significant first, one per cycle. `done` rises N+1 clock edges after the edge that accepts `start`.
- R6: `done` is high for exactly one cycle. `result` changes only in the cycle in which `done` rises and holds its value otherwise.
- R7: A `start` that arrives while a computation is running is ignored. The running result is unaffected by it and by any change of `samples`.
- R8: All samples at −1 (every bit set) give −ΣCOEFS.
- R9: The accumulator cannot overflow. The largest positive and largest negative dot products both come out exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe, accepted only when idle |
| samples | input | K*N | K packed samples, lane k at bits k*N +: N |
| result | output | M+clog2(K)+N+2 | Signed dot product, registered |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bound checker watches, on every cycle, the one-cycle shape of `done`, that `result` holds between completions, that the sign slice is the last one applied before completion, that a `start` during a run does not restart it, and that the accumulator sum never overflows its sign bit. The arithmetic itself can only be shown by the bench's scenarios: the table contents through one-hot inputs, the exact sum over random samples, the sign handling at the most negative and all-ones values, the N+1 latency and the ignored mid-run start. The bench checks all of these against an integer dot product that it computes itself.

// File: rtl/da_pkg.sv
package da_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } run_phase_t;

endpackage

// File: rtl/da_bit_feeder.sv
module da_bit_feeder
  import da_pkg::*;
#(
  parameter int K = 4,
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [K*N-1:0] samples,
  output logic           busy,
  output logic [K-1:0]   slice,
  output logic           slice_vld,
  output logic           slice_first,
  output logic           slice_last
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;

  run_phase_t     phase_q;
  logic [CW-1:0]  bit_cnt_q;
  logic           accept;

  assign accept = start && (phase_q == PH_IDLE);
  assign busy   = (phase_q == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
    end else if (accept) begin
      phase_q   <= PH_RUN;
      bit_cnt_q <= '0;
    end else if (phase_q == PH_RUN) begin
      if (bit_cnt_q == CW'(N - 1)) begin
        phase_q <= PH_IDLE;
      end
      bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [N-1:0] sreg_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sreg_q <= '0;
      end else if (accept) begin
        sreg_q <= samples[k*N +: N];
      end else if (phase_q == PH_RUN) begin
        sreg_q <= {1'b0, sreg_q[N-1:1]};
      end
    end
    assign slice[k] = sreg_q[0];
  end

  assign slice_vld   = busy;
  assign slice_first = busy && (bit_cnt_q == '0);
  assign slice_last  = busy && (bit_cnt_q == CW'(N - 1));

endmodule

// File: rtl/da_coef_rom.sv
module da_coef_rom #(
  parameter int K = 4,
  parameter int M = 12,
  parameter logic [K*M-1:0] COEFS = '0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [K-1:0]                        addr,
  input  logic                                in_vld,
  input  logic                                in_first,
  input  logic                                in_last,
  output logic signed [M+$clog2(K)-1:0]       rd_data,
  output logic                                rd_vld,
  output logic                                rd_first,
  output logic                                rd_last
);

  localparam int TW    = M + $clog2(K);
  localparam int DEPTH = 1 << K;

  function automatic logic signed [TW-1:0] entry_val(input int e);
    logic signed [TW-1:0] acc;
    acc = '0;
    for (int k = 0; k < K; k++) begin
      if (((e >> k) & 1) == 1) begin
        acc = acc + TW'($signed(COEFS[k*M +: M]));
      end
    end
    return acc;
  endfunction

  logic signed [TW-1:0] table_mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam logic signed [TW-1:0] ENT = entry_val(e);
    assign table_mem[e] = ENT;
  end

  always_ff @(posedge clk) begin
    rd_data <= table_mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld   <= 1'b0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_vld   <= in_vld;
      rd_first <= in_first;
      rd_last  <= in_last;
    end
  end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
  parameter int TW = 14,
  parameter int N  = 8,
  parameter int AW = TW + N + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [TW-1:0] term,
  input  logic                 term_vld,
  input  logic                 term_first,
  input  logic                 term_last,
  output logic signed [AW-1:0] result,
  output logic                 done,
  output logic signed [AW-1:0] acc_sum
);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] base;
  logic signed [AW-1:0] scaled;
  logic signed [AW-1:0] nxt;

  assign base    = term_first ? '0 : acc_q;
  assign scaled  = AW'(term) <<< N;
  assign acc_sum = term_last ? (base - scaled) : (base + scaled);
  assign nxt     = acc_sum >>> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (term_vld) begin
        acc_q <= nxt;
        if (term_last) begin
          result <= nxt;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/da_dot_product.sv
module da_dot_product #(
  parameter int K = 4,
  parameter int N = 8,
  parameter int M = 12,
  parameter logic [K*M-1:0] COEFS = {12'h0E1, 12'h79A, 12'hD9A, 12'h5C3}
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [K*N-1:0]                    samples,
  output logic signed [M+$clog2(K)+N+1:0]   result,
  output logic                              done
);

  localparam int TW = M + $clog2(K);
  localparam int AW = TW + N + 2;

  logic                 busy;
  logic [K-1:0]         slice;
  logic                 slice_vld;
  logic                 slice_first;
  logic                 slice_last;
  logic signed [TW-1:0] rd_data;
  logic                 rd_vld;
  logic                 rd_first;
  logic                 rd_last;
  logic signed [AW-1:0] acc_sum;

  da_bit_feeder #(.K(K), .N(N)) u_feed (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .samples     (samples),
    .busy        (busy),
    .slice       (slice),
    .slice_vld   (slice_vld),
    .slice_first (slice_first),
    .slice_last  (slice_last)
  );

  da_coef_rom #(.K(K), .M(M), .COEFS(COEFS)) u_rom (
    .clk      (clk),
    .rst      (rst),
    .addr     (slice),
    .in_vld   (slice_vld),
    .in_first (slice_first),
    .in_last  (slice_last),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld),
    .rd_first (rd_first),
    .rd_last  (rd_last)
  );

  da_shift_acc #(.TW(TW), .N(N), .AW(AW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .term       (rd_data),
    .term_vld   (rd_vld),
    .term_first (rd_first),
    .term_last  (rd_last),
    .result     (result),
    .done       (done),
    .acc_sum    (acc_sum)
  );

endmodule

// File: rtl/da_dot_product_chk.sv
module da_dot_product_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          slice_first,
  input logic          slice_last,
  input logic          rd_vld,
  input logic          rd_last,
  input logic          done,
  input logic [AW-1:0] result,
  input logic [AW-1:0] acc_sum
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done && !busy)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result)); // R6

  AST_SIGN_LAST: assert property (@(posedge clk) disable iff (rst) done |-> $past(rd_last)); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !slice_last) |=> (busy && !slice_first)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> (acc_sum[AW-1] == acc_sum[AW-2])); // R9

endmodule

bind da_dot_product da_dot_product_chk #(.AW(M + $clog2(K) + N + 2)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .slice_first (slice_first),
  .slice_last  (slice_last),
  .rd_vld      (rd_vld),
  .rd_last     (rd_last),
  .done        (done),
  .result      (result),
  .acc_sum     (acc_sum)
);

// File: tb/test_da_dot_product.sv
module test_da_dot_product;

  localparam int K  = 4;
  localparam int N  = 8;
  localparam int M  = 12;
  localparam int RW = M + 2 + N + 2;

  localparam int CF[K] = '{1475, -614, 1946, 225};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [K*N-1:0]  samples = '0;
  logic [RW-1:0]   result;
  logic            done;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  da_dot_product #(.K(K), .N(N), .M(M)) i_da_dot_product (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .samples (samples),
    .result  (result),
    .done    (done)
  );

  function automatic longint ref_dot(input int xs[K]);
    longint s = 0;
    for (int k = 0; k < K; k++) s += longint'(CF[k]) * longint'(xs[k]);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int xs[K], input string req, input bit poke);
    int lat;
    longint exp;
    longint got;
    logic [RW-1:0] held;
    for (int k = 0; k < K; k++) samples[k*N +: N] = xs[k][N-1:0];
    exp = ref_dot(xs);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 3) begin
        samples = ~samples;
        start   = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
    chk(lat == N + 1, "R5 latency", lat, N + 1);
    got = longint'($signed(result));
    chk(got == exp, req, got, exp);
    held = result;
    @(posedge clk);
    @(negedge clk);
    chk(!done && result == held, "R6 done single and result held",
        longint'(done), 0);
  endtask

  initial begin
    int xs[K];
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 after reset", longint'($signed(result)), 0);

    xs = '{0, 0, 0, 0};
    run(xs, "R3 entry zero", 1'b0);
    for (int k = 0; k < K; k++) begin
      xs = '{0, 0, 0, 0};
      xs[k] = 1;
      run(xs, "R3 one-hot lane", 1'b0);
    end
    xs = '{-1, -1, -1, -1};
    run(xs, "R8 all ones", 1'b0);
    xs = '{-128, -128, -128, -128};
    run(xs, "R4 most negative", 1'b0);
    xs = '{-128, 127, -128, -128};
    run(xs, "R9 extreme negative", 1'b0);
    xs = '{127, -128, 127, 127};
    run(xs, "R9 extreme positive", 1'b0);
    xs = '{100, -57, 3, -90};
    run(xs, "R7 start during run ignored", 1'b1);
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < K; k++) xs[k] = int'($urandom_range(255)) - 128;
      run(xs, "R2 random", 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule